// File: doc/BRIEF.md
# Self-Correcting Ring / Twisted-Ring Counter

A shift-register counter of parameterised width that runs as either a one-hot ring or a twisted ring (Johnson style). The `mode` input picks the next-state logic. The ring cycle has WIDTH states. The twisted cycle has 2·WIDTH states, because the inverted top bit is fed back into bit 0. A registered `wrap` output rises for one cycle each time the counter returns to its start value from the final value of its cycle. Controllers use it to sequence phases, to divide clocks and to run a timeslot scheduler.

Both next-state functions correct themselves. In ring mode, the bit shifted in depends on whether the lower bits that stay in the register are all zero. Any corrupted pattern therefore becomes one-hot after a few enabled clocks. In twisted mode, any pattern that is not a thermometer code is cleared to zero, which is the start of the cycle. If `mode` changes while the counter is out of reset, the register is not reloaded. The new mode's correction logic treats the current contents like any other possibly illegal state.

Top module: `shctr_top`

## Requirements
- R1: Reset is synchronous and active-low, and it overrides `en`. A clock edge with `rst_n`=0 loads 0…01 (only bit 0 set) when `mode`=0 (ring), and all zeros when `mode`=1 (twisted).
- R2: When `en`=0 and `rst_n`=1, `state` holds its value and `wrap` is 0 after the edge, whatever the value of `mode`.
- R3: In ring mode, each enabled edge shifts `state` one place toward the MSB. For WIDTH=4 the sequence is 0001, 0010, 0100, 1000, 0001.
- R4: In twisted mode, each enabled edge on a legal state shifts toward the MSB, and the complement of the MSB enters bit 0. For WIDTH=4 the sequence is 0000, 0001, 0011, 0111, 1111, 1110, 1100, 1000, 0000.
- R5: In ring mode, the bit entering position 0 is 1 exactly when bits WIDTH-2..0 are all 0. Any starting value becomes one-hot within WIDTH-1 enabled edges and stays one-hot after that.
- R6: In twisted mode, a state with more than one adjacent-bit difference is illegal. An illegal state goes to all zeros on the next enabled edge. A legal state is one whose bit i and bit i+1 differ for at most one i.
- R7: `wrap` is 1 for exactly the one cycle after an enabled, non-reset edge that leaves the state 10…0 (only the MSB set). It is 0 at every other time.
- R8: `mode` is applied at every edge without reloading the register. Changing it outside reset applies the new mode's next-state and correction rules (R5, R6) to the current contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Advance enable |
| mode | input | 1 | 0 = one-hot ring, 1 = twisted ring |
| state | output | WIDTH | Counter register |
| wrap | output | 1 | One-cycle pulse after return to the start value |

## Verification
The bench runs both full legal cycles from reset. These runs separate the two shift directions and the two feedback rules, and they locate the `wrap` pulse against the final state. It then switches `mode` after every possible number of advances in each mode. The twisted phases pushed into ring mode include several multi-bit patterns that exercise the all-zero-lower-bits feed-in and its recovery bound. The ring phases pushed into twisted mode separate legal single-bit patterns from illegal ones, which must clear to zero. Holds with `en` low while `mode` toggles show that the enable gates both the register and the pulse.

// File: rtl/shctr_pkg.sv
// Package: shared mode encoding for the self-correcting shift counter.
// Assumes: a single mode bit; 0 selects one-hot ring, 1 selects twisted ring.
package shctr_pkg;
    typedef enum logic {
        MODE_RING  = 1'b0,
        MODE_TWIST = 1'b1
    } ctr_mode_e;
endpackage

// File: rtl/shctr_ring_next.sv
// Module: next-state logic for the one-hot ring, with self-correction.
// Shifts toward the MSB. Bit 0 takes 1 only when every lower bit that stays
// in the register is 0, so any pattern drains to a single 1.
// Assumes: WIDTH >= 2. Purely combinational.
module shctr_ring_next #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt
);
    localparam int KEEP = WIDTH - 1;

    logic keep_zero;

    // Purpose: detect that the bits surviving the shift are all clear.
    always_comb begin
        keep_zero = ~|cur[KEEP-1:0];
    end

    // Purpose: build the shifted value with the corrective feed bit.
    always_comb begin
        nxt = {cur[KEEP-1:0], keep_zero};
    end
endmodule

// File: rtl/shctr_twist_next.sv
// Module: next-state logic for the twisted ring, with illegal-code clearing.
// A legal code has at most one boundary between adjacent bits. Any other
// code is sent to zero, the start of the legal cycle.
// Assumes: WIDTH >= 2. Purely combinational.
module shctr_twist_next #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt,
    output logic             illegal
);
    localparam int CW = $clog2(WIDTH) + 1;

    logic [WIDTH-2:0] edges;
    logic [CW-1:0]    n_edges;

    // Purpose: mark every position where neighbouring bits differ.
    always_comb begin
        edges = cur[WIDTH-1:1] ^ cur[WIDTH-2:0];
    end

    // Purpose: count the boundaries in the pattern.
    always_comb begin
        n_edges = '0;
        for (int i = 0; i < WIDTH - 1; i++) begin
            n_edges = n_edges + CW'(edges[i]);
        end
    end

    // Purpose: flag the pattern as illegal when it has two or more boundaries.
    always_comb begin
        illegal = (n_edges > CW'(1));
    end

    // Purpose: shift in the inverted MSB, or clear when illegal.
    always_comb begin
        if (illegal) begin
            nxt = '0;
        end else begin
            nxt = {cur[WIDTH-2:0], ~cur[WIDTH-1]};
        end
    end
endmodule

// File: rtl/shctr_top.sv
// Module: self-correcting ring / twisted-ring shift counter.
// Holds the state register, selects the next state by mode, and registers
// a one-cycle pulse for the return from the final state to the start.
// Assumes: synchronous active-low reset; WIDTH >= 2; mode is used live at
// every edge, so no reload happens on a mode change.
module shctr_top
    import shctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             mode,
    output logic [WIDTH-1:0] state,
    output logic             wrap
);
    localparam logic [WIDTH-1:0] RING_START  = WIDTH'(1);
    localparam logic [WIDTH-1:0] TWIST_START = '0;
    localparam logic [WIDTH-1:0] LAST_STATE  = {1'b1, {(WIDTH-1){1'b0}}};
    localparam int               BW          = $clog2(WIDTH) + 1;

    ctr_mode_e        mode_sel;
    logic [WIDTH-1:0] ring_nxt;
    logic [WIDTH-1:0] twist_nxt;
    logic             twist_bad;
    logic [WIDTH-1:0] state_d;
    logic             wrap_d;

    // Purpose: map the raw mode pin onto the shared encoding.
    always_comb begin
        mode_sel = ctr_mode_e'(mode);
    end

    shctr_ring_next #(.WIDTH(WIDTH)) u_ring (
        .cur (state),
        .nxt (ring_nxt)
    );

    shctr_twist_next #(.WIDTH(WIDTH)) u_twist (
        .cur     (state),
        .nxt     (twist_nxt),
        .illegal (twist_bad)
    );

    // Purpose: choose the next register value by reset, enable and mode.
    always_comb begin
        if (!rst_n) begin
            state_d = (mode_sel == MODE_RING) ? RING_START : TWIST_START;
        end else if (!en) begin
            state_d = state;
        end else if (mode_sel == MODE_RING) begin
            state_d = ring_nxt;
        end else begin
            state_d = twist_nxt;
        end
    end

    // Purpose: the final state returns to the start value in both modes.
    always_comb begin
        wrap_d = rst_n && en && (state == LAST_STATE);
    end

    // Purpose: state and pulse registers.
    always_ff @(posedge clk) begin
        state <= state_d;
        wrap  <= wrap_d;
    end

    // ---------------- assertions ----------------
    logic          past_ok;
    logic [BW-1:0] ring_bad_run;

    // Purpose: mark that at least one edge has happened.
    always_ff @(posedge clk) begin
        past_ok <= 1'b1;
    end

    // Purpose: count enabled ring-mode edges that start from a non-one-hot state.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_sel != MODE_RING) begin
            ring_bad_run <= '0;
        end else if (en) begin
            if (!$onehot(state)) begin
                ring_bad_run <= ring_bad_run + BW'(1);
            end else begin
                ring_bad_run <= '0;
            end
        end
    end

    AST_RESET_LOAD: assert property (@(posedge clk)
        (past_ok === 1'b1 && $past(rst_n) == 1'b0) |->
            (state == ($past(mode) ? TWIST_START : RING_START))); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> ($stable(state) && !wrap)); // R2

    AST_RING_STAYS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode_sel == MODE_RING && $onehot(state)) |=> $onehot(state)); // R5

    AST_RING_RECOVER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ring_bad_run < BW'(WIDTH)); // R5

    AST_TWIST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode_sel == MODE_TWIST && twist_bad) |=> (state == '0)); // R6

    AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> !wrap); // R7
endmodule

// File: tb/sim_shctr_top.sv
module sim_shctr_top;
    localparam int N = 4;
    localparam logic [N-1:0] MASK = {N{1'b1}};
    localparam logic [N-1:0] LOWM = {1'b0, {(N-1){1'b1}}};
    localparam logic [N-1:0] LASTV = {1'b1, {(N-1){1'b0}}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic mode = 1'b0;
    logic [N-1:0] state;
    logic wrap;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [N-1:0] exp_s;
    logic exp_w;

    always #5 clk = ~clk;

    shctr_top #(.WIDTH(N)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode),
        .state(state), .wrap(wrap)
    );

    function automatic logic [N-1:0] ring_model(input logic [N-1:0] s);
        logic [N-1:0] r;
        r = (s << 1) & MASK;
        if ((s & LOWM) == 0) r = r | N'(1);
        return r;
    endfunction

    function automatic bit twist_legal(input logic [N-1:0] s);
        for (int k = 0; k <= N; k++) begin
            logic [N-1:0] t;
            t = N'((2 ** k) - 1);
            if (s == t || s == (MASK ^ t)) return 1;
        end
        return 0;
    endfunction

    function automatic logic [N-1:0] twist_model(input logic [N-1:0] s);
        if (!twist_legal(s)) return '0;
        return ((s << 1) & MASK) | N'(s[N-1] ? 0 : 1);
    endfunction

    task automatic check(input string tag, input logic [N-1:0] es, input logic ew);
        total++;
        if (state !== es) begin
            bad++;
            $display("FAIL %s state actual=%b expected=%b", tag, state, es);
        end
        total++;
        if (wrap !== ew) begin
            bad++;
            $display("FAIL %s wrap actual=%b expected=%b", tag, wrap, ew);
        end
    endtask

    // apply inputs mid-cycle, take one edge, update model, check after the edge
    task automatic tick(input logic r, input logic e, input logic m, input string tag);
        logic [N-1:0] ns;
        rst_n = r; en = e; mode = m;
        @(posedge clk);
        if (!r) ns = m ? '0 : N'(1);
        else if (!e) ns = exp_s;
        else if (!m) ns = ring_model(exp_s);
        else ns = twist_model(exp_s);
        exp_w = r && e && (exp_s == LASTV) && (ns == (m ? '0 : N'(1)));
        exp_s = ns;
        #1;
        check(tag, exp_s, exp_w);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        exp_s = '0; exp_w = 0;
        #1;
        // R1: reset with en high, ring start value
        tick(0, 1, 0, "R1 ring reset");
        tick(0, 0, 0, "R1 ring reset");
        // R3 + R7: full ring cycle twice
        for (int i = 0; i < 2 * N + 1; i++) tick(1, 1, 0, "R3/R7 ring run");
        // drive to last state, then hold: R2
        while (exp_s != LASTV) tick(1, 1, 0, "R3 ring run");
        for (int i = 0; i < 3; i++) tick(1, 0, i % 2, "R2 hold");
        tick(1, 1, 0, "R7 wrap after hold");
        // R1 twisted reset, R4 + R7 two full cycles
        tick(0, 1, 1, "R1 twist reset");
        for (int i = 0; i < 4 * N + 1; i++) tick(1, 1, 1, "R4/R7 twist run");
        // R8 + R5: every twisted phase pushed into ring mode
        for (int k = 0; k < 2 * N; k++) begin
            int steps;
            tick(0, 1, 1, "R1 twist reset");
            for (int i = 0; i < k; i++) tick(1, 1, 1, "R4 twist run");
            steps = 0;
            for (int i = 0; i < N + 1; i++) begin
                tick(1, 1, 0, "R5/R8 ring recovery");
                if (!$onehot(exp_s) && i < N) steps = i + 1;
            end
            total++;
            if (!$onehot(state) || steps > N - 1) begin
                bad++;
                $display("FAIL R5 recovery actual=%b steps=%0d expected one-hot within %0d",
                         state, steps, N - 1);
            end
        end
        // R8 + R6: every ring phase pushed into twisted mode
        for (int k = 0; k < N; k++) begin
            tick(0, 1, 0, "R1 ring reset");
            for (int i = 0; i < k; i++) tick(1, 1, 0, "R3 ring run");
            for (int i = 0; i < 2 * N + 1; i++) tick(1, 1, 1, "R6/R8 twist recovery");
        end
        // R2: mode toggles with enable low leave state alone
        tick(0, 1, 1, "R1 twist reset");
        tick(1, 1, 1, "R4 twist run");
        tick(1, 1, 1, "R4 twist run");
        for (int i = 0; i < 4; i++) tick(1, 0, i % 2, "R2 hold mode toggle");
        tick(1, 1, 1, "R4 twist resume");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule